// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the programming front end of an eight-line priority interrupt controller. Software writes bytes to it through a small register bus with two addresses. The command address (port 0) takes the first initialization byte and the run-time commands. The data address (port 1) takes the later initialization bytes and the mask. The block sorts each write into a command class. It follows the initialization sequence with a phase register, and it holds the mask register and the in-service register. When software signals that an interrupt has been serviced, the block clears the matching in-service bit.

The block does not resolve priority, run an acknowledge cycle, produce a vector or handle cascading. The `isr_set` input stands in for an acknowledge. It marks lines as in service so that the end-of-service commands have something to clear. Any write the block cannot accept on the command address raises a one-cycle error pulse.

Top module: `irq_cmd_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to the idle phase (`phase` = 0). It clears `isr`, `imr`, the four init registers, `ocw2_q`, `ocw3_q` and `err`.
- R2: A port 0 write with bit 4 = 1 is an init-start byte and is accepted in every phase. It is stored in `icw1_q`, and `phase` becomes 1 (waiting for the second init byte).
- R3: In phase 1, a port 1 write is stored in `icw2_q`. The next phase is chosen in priority order. If `icw1_q` bit 1 (single) is 0, the next phase is 2. Otherwise, if `icw1_q` bit 0 (fourth byte needed) is 1, the next phase is 3. Otherwise the next phase is 4 (ready).
- R4: In phase 2, a port 1 write is stored in `icw3_q`. The next phase is 3 if `icw1_q` bit 0 is 1, and 4 otherwise.
- R5: In phase 3, a port 1 write is stored in `icw4_q`, and the phase becomes 4.
- R6: In phase 0 or phase 4, a port 1 write loads the byte into `imr`. No other register and not `phase` changes.
- R7: A port 0 byte with bits 4 and 3 both 0 is an end-of-service command. Its fields are: level in bits 2:0, EOI in bit 5, SL in bit 6 and R in bit 7. In phase 4, the combination EOI=1, SL=1, R=0 clears the `isr` bit selected by the level field and stores the byte in `ocw2_q`.
- R8: In phase 4, the combination EOI=1, SL=0, R=0 clears only the lowest-numbered set `isr` bit. If no bit is set, `isr` does not change. The byte is stored in `ocw2_q`. At most one `isr` bit is cleared per cycle.
- R9: In phase 4, an end-of-service byte with any other EOI/SL/R combination raises `err`. It leaves `isr`, `ocw2_q` and `phase` unchanged.
- R10: A port 0 byte with bit 4 = 0 and bit 3 = 1 is a mode byte. In phase 4 it is stored in `ocw3_q`.
- R11: In phases 0 to 3, a port 0 write with bit 4 = 0 raises `err`. It changes no register and does not change `phase`.
- R12: `isr_set` ORs bits into `isr` in the same cycle as any end-of-service clear. The clear is chosen from `isr` as it stood before that edge. When a clear and a set hit the same bit, the clear wins.
- R13: `err` is registered. It is high for exactly the cycle after each rejected port 0 write. Port 1 writes and accepted writes never raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_port | input | 1 | Address: 0 = command byte, 1 = data byte |
| wr_data | input | 8 | Write data |
| isr_set | input | 8 | Test hook: lines to mark as in service |
| phase | output | 3 | Sequencer phase: 0 idle, 1/2/3 waiting for the 2nd/3rd/4th byte, 4 ready |
| imr | output | 8 | Interrupt mask register |
| isr | output | 8 | In-service register |
| icw1_q | output | 8 | Stored init-start byte |
| icw2_q | output | 8 | Stored second init byte |
| icw3_q | output | 8 | Stored third init byte |
| icw4_q | output | 8 | Stored fourth init byte |
| ocw2_q | output | 8 | Last accepted end-of-service byte |
| ocw3_q | output | 8 | Last accepted mode byte |
| err | output | 1 | Rejected-write pulse |

## Verification
The init sequence is run with all four settings of the single and fourth-byte-needed bits. Each setting must take its own phase path. An init-start byte sent in the middle of a sequence checks that the sequence restarts. End-of-service clears are tried first with only one `isr` bit set. They are then tried with several bits set, where the specific form and the lowest-bit form pick different bits. A non-specific clear with `isr` empty checks that it has no effect. Set and clear are driven in the same cycle on the same bit, and on different bits. This separates "clear wins" from "set wins", and it shows whether the lowest-bit choice is made from the old `isr` or the merged one. Rejected bytes are sent both before the ready phase and in it, with illegal EOI/SL/R combinations. Each time, the bench checks that the outputs are unchanged and that `err` pulses.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int BYTE_W  = 8;
  localparam int LINES   = 8;
  localparam int LVL_W   = $clog2(LINES);
  localparam int PHASE_W = 3;

  // command byte bit positions
  localparam int B_INIT   = 4;
  localparam int B_MODE   = 3;
  localparam int B_EOI    = 5;
  localparam int B_SL     = 6;
  localparam int B_ROT    = 7;
  localparam int B_NEED4  = 0;
  localparam int B_SINGLE = 1;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE  = 3'd0,
    PH_W2    = 3'd1,
    PH_W3    = 3'd2,
    PH_W4    = 3'd3,
    PH_READY = 3'd4
  } phase_e;

  function automatic phase_e after_second(input logic [BYTE_W-1:0] first);
    if (!first[B_SINGLE])    return PH_W3;
    else if (first[B_NEED4]) return PH_W4;
    else                     return PH_READY;
  endfunction

  function automatic phase_e after_third(input logic [BYTE_W-1:0] first);
    return first[B_NEED4] ? PH_W4 : PH_READY;
  endfunction

  // isolate the least significant set bit
  function automatic logic [LINES-1:0] lowest_one(input logic [LINES-1:0] v);
    return v & (~v + LINES'(1));
  endfunction

  function automatic logic [LINES-1:0] level_onehot(input logic [LVL_W-1:0] lvl);
    return LINES'(1) << lvl;
  endfunction
endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
  import irq_seq_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic              wr_en,
  input  logic              wr_port,
  input  logic [DW-1:0]     wr_data,
  input  logic [PHASE_W-1:0] phase,
  output logic              go_init,
  output logic              init_data,
  output logic              ld_mask,
  output logic              eoi_spec,
  output logic              eoi_low,
  output logic              ld_mode,
  output logic              reject
);
  logic cmd_wr, dat_wr, ready, in_init, is_end, is_mode;

  always_comb begin
    cmd_wr    = wr_en & ~wr_port;
    dat_wr    = wr_en & wr_port;
    ready     = (phase == PH_READY);
    in_init   = (phase == PH_W2) | (phase == PH_W3) | (phase == PH_W4);
    is_end    = ~wr_data[B_INIT] & ~wr_data[B_MODE];
    is_mode   = ~wr_data[B_INIT] &  wr_data[B_MODE];

    go_init   = cmd_wr & wr_data[B_INIT];
    init_data = dat_wr & in_init;
    ld_mask   = dat_wr & ((phase == PH_IDLE) | ready);
    eoi_spec  = cmd_wr & ready & is_end & wr_data[B_EOI] & ~wr_data[B_ROT] &  wr_data[B_SL];
    eoi_low   = cmd_wr & ready & is_end & wr_data[B_EOI] & ~wr_data[B_ROT] & ~wr_data[B_SL];
    ld_mode   = cmd_wr & ready & is_mode;
    reject    = cmd_wr & ~go_init & ~eoi_spec & ~eoi_low & ~ld_mode;
  end
endmodule

// File: rtl/irq_init_fsm.sv
module irq_init_fsm
  import irq_seq_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go_init,
  input  logic               init_data,
  input  logic [DW-1:0]      wr_data,
  output logic [PHASE_W-1:0] phase,
  output logic [DW-1:0]      icw1_q,
  output logic [DW-1:0]      icw2_q,
  output logic [DW-1:0]      icw3_q,
  output logic [DW-1:0]      icw4_q
);
  phase_e ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      icw1_q <= '0;
      icw2_q <= '0;
      icw3_q <= '0;
      icw4_q <= '0;
    end else if (go_init) begin
      ph_q   <= PH_W2;
      icw1_q <= wr_data;
    end else if (init_data) begin
      unique case (ph_q)
        PH_W2: begin
          icw2_q <= wr_data;
          ph_q   <= after_second(icw1_q);
        end
        PH_W3: begin
          icw3_q <= wr_data;
          ph_q   <= after_third(icw1_q);
        end
        PH_W4: begin
          icw4_q <= wr_data;
          ph_q   <= PH_READY;
        end
        default: ph_q <= ph_q;
      endcase
    end
  end

  assign phase = ph_q;
endmodule

// File: rtl/irq_isr_unit.sv
module irq_isr_unit
  import irq_seq_pkg::*;
#(
  parameter int N  = LINES,
  parameter int LW = LVL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eoi_spec,
  input  logic          eoi_low,
  input  logic [LW-1:0] level,
  input  logic [N-1:0]  isr_set,
  output logic [N-1:0]  isr,
  output logic [N-1:0]  isr_clr
);
  logic [N-1:0] isr_q;

  always_comb begin
    isr_clr = '0;
    if (eoi_spec)     isr_clr = level_onehot(level);
    else if (eoi_low) isr_clr = lowest_one(isr_q);
  end

  always_ff @(posedge clk) begin
    if (rst) isr_q <= '0;
    else     isr_q <= (isr_q | isr_set) & ~isr_clr;
  end

  assign isr = isr_q;
endmodule

// File: rtl/irq_cmd_seq.sv
module irq_cmd_seq
  import irq_seq_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int N  = LINES,
  localparam int LW = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_port,
  input  logic [DW-1:0]      wr_data,
  input  logic [N-1:0]       isr_set,
  output logic [PHASE_W-1:0] phase,
  output logic [N-1:0]       imr,
  output logic [N-1:0]       isr,
  output logic [DW-1:0]      icw1_q,
  output logic [DW-1:0]      icw2_q,
  output logic [DW-1:0]      icw3_q,
  output logic [DW-1:0]      icw4_q,
  output logic [DW-1:0]      ocw2_q,
  output logic [DW-1:0]      ocw3_q,
  output logic               err
);
  logic go_init, init_data, ld_mask, eoi_spec, eoi_low, ld_mode, reject;
  logic [N-1:0] isr_clr;

  irq_cmd_decode #(.DW(DW)) u_dec (
    .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data), .phase(phase),
    .go_init(go_init), .init_data(init_data), .ld_mask(ld_mask),
    .eoi_spec(eoi_spec), .eoi_low(eoi_low), .ld_mode(ld_mode), .reject(reject)
  );

  irq_init_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .go_init(go_init), .init_data(init_data),
    .wr_data(wr_data), .phase(phase),
    .icw1_q(icw1_q), .icw2_q(icw2_q), .icw3_q(icw3_q), .icw4_q(icw4_q)
  );

  irq_isr_unit #(.N(N), .LW(LW)) u_isr (
    .clk(clk), .rst(rst), .eoi_spec(eoi_spec), .eoi_low(eoi_low),
    .level(wr_data[LW-1:0]), .isr_set(isr_set),
    .isr(isr), .isr_clr(isr_clr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      imr    <= '0;
      ocw2_q <= '0;
      ocw3_q <= '0;
      err    <= 1'b0;
    end else begin
      err <= reject;
      if (ld_mask)             imr    <= wr_data[N-1:0];
      if (eoi_spec || eoi_low) ocw2_q <= wr_data;
      if (ld_mode)             ocw3_q <= wr_data;
    end
  end
endmodule

// File: rtl/irq_cmd_seq_chk.sv
module irq_cmd_seq_chk #(
  parameter int DW = 8,
  parameter int N  = 8,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          wr_port,
  input logic [DW-1:0] wr_data,
  input logic [N-1:0]  isr_set,
  input logic [PW-1:0] phase,
  input logic [N-1:0]  imr,
  input logic [N-1:0]  isr,
  input logic [DW-1:0] icw1_q,
  input logic [DW-1:0] ocw2_q,
  input logic          err,
  input logic [N-1:0]  isr_clr
);
  AST_INIT_START_ANY_PHASE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_port && wr_data[4]) |=> (phase == 3'd1 && icw1_q == $past(wr_data))); // R2

  AST_FOURTH_TO_READY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_port && phase == 3'd3) |=> (phase == 3'd4)); // R5

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_port && (phase == 3'd0 || phase == 3'd4)) |=> (imr == $past(wr_data[N-1:0]))); // R6

  AST_ONE_CLEAR_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0($past(isr) & ~isr)); // R8

  AST_REJECT_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    err |-> ($stable(phase) && $stable(ocw2_q))); // R11

  AST_ERR_FROM_CMD_WRITE: assert property (@(posedge clk) disable iff (rst)
    err |-> ($past(wr_en) && !$past(wr_port))); // R13

  AST_SET_REACHES_ISR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((isr & ($past(isr_set) & ~$past(isr_clr))) == ($past(isr_set) & ~$past(isr_clr)))); // R12
endmodule

bind irq_cmd_seq irq_cmd_seq_chk #(.DW(DW), .N(N), .PW(irq_seq_pkg::PHASE_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
  .isr_set(isr_set), .phase(phase), .imr(imr), .isr(isr), .icw1_q(icw1_q),
  .ocw2_q(ocw2_q), .err(err), .isr_clr(isr_clr)
);

// File: tb/irq_cmd_seq_bench.sv
module irq_cmd_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] P_IDLE = 3'd0, P_SECOND = 3'd1, P_THIRD = 3'd2,
                         P_FOURTH = 3'd3, P_READY = 3'd4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_port = 1'b0;
  logic [7:0] wr_data = '0, isr_set = '0;
  logic [2:0] phase;
  logic [7:0] imr, isr, icw1_q, icw2_q, icw3_q, icw4_q, ocw2_q, ocw3_q;
  logic err;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cmd_seq u_irq_cmd_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
    .isr_set(isr_set), .phase(phase), .imr(imr), .isr(isr),
    .icw1_q(icw1_q), .icw2_q(icw2_q), .icw3_q(icw3_q), .icw4_q(icw4_q),
    .ocw2_q(ocw2_q), .ocw3_q(ocw3_q), .err(err)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus; results are visible at the returning negedge
  task automatic drive(input logic en, input logic port, input logic [7:0] d, input logic [7:0] s);
    @(negedge clk);
    wr_en = en; wr_port = port; wr_data = d; isr_set = s;
    @(negedge clk);
    wr_en = 1'b0; isr_set = '0;
  endtask

  task automatic wr(input logic port, input logic [7:0] d);
    drive(1'b1, port, d, 8'h00);
  endtask

  task automatic mark(input logic [7:0] s);
    drive(1'b0, 1'b0, 8'h00, s);
  endtask

  function automatic logic [7:0] clear_lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) begin v[i] = 1'b0; return v; end
    return v;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    mark(8'hFF); wr(1'b0, 8'h11);
    do_reset();
    check("R1", "phase", {5'd0, phase}, {5'd0, P_IDLE});
    check("R1", "isr", isr, 8'h00);
    check("R1", "imr", imr, 8'h00);
    check("R1", "icw1", icw1_q, 8'h00);
    check("R1", "ocw2|ocw3", ocw2_q | ocw3_q, 8'h00);
    check("R1", "err", {7'd0, err}, 8'h00);
  endtask

  task automatic t_mask_idle();
    do_reset();
    wr(1'b1, 8'hA5);
    check("R6", "imr in idle", imr, 8'hA5);
    check("R6", "phase kept", {5'd0, phase}, {5'd0, P_IDLE});
    check("R13", "no err on port 1", {7'd0, err}, 8'h00);
  endtask

  // cascade (single=0), fourth byte needed
  task automatic t_init_cascade_need4();
    do_reset();
    wr(1'b0, 8'h11);
    check("R2", "phase after start", {5'd0, phase}, {5'd0, P_SECOND});
    check("R2", "icw1", icw1_q, 8'h11);
    wr(1'b1, 8'h20);
    check("R3", "icw2", icw2_q, 8'h20);
    check("R3", "phase cascade", {5'd0, phase}, {5'd0, P_THIRD});
    wr(1'b1, 8'h04);
    check("R4", "icw3", icw3_q, 8'h04);
    check("R4", "phase need4", {5'd0, phase}, {5'd0, P_FOURTH});
    wr(1'b1, 8'h01);
    check("R5", "icw4", icw4_q, 8'h01);
    check("R5", "phase ready", {5'd0, phase}, {5'd0, P_READY});
    wr(1'b1, 8'h3C);
    check("R6", "imr in ready", imr, 8'h3C);
  endtask

  task automatic t_init_single_no4();
    do_reset();
    wr(1'b0, 8'h12); wr(1'b1, 8'h40);
    check("R3", "single no icw4 -> ready", {5'd0, phase}, {5'd0, P_READY});
    check("R6", "imr not touched by init byte", imr, 8'h00);
  endtask

  task automatic t_init_single_need4();
    do_reset();
    wr(1'b0, 8'h13); wr(1'b1, 8'h48);
    check("R3", "single need4 -> fourth", {5'd0, phase}, {5'd0, P_FOURTH});
    wr(1'b1, 8'h03);
    check("R5", "icw4 single", icw4_q, 8'h03);
    check("R5", "ready", {5'd0, phase}, {5'd0, P_READY});
  endtask

  task automatic t_init_cascade_no4();
    do_reset();
    wr(1'b0, 8'h10); wr(1'b1, 8'h08);
    check("R3", "cascade -> third", {5'd0, phase}, {5'd0, P_THIRD});
    wr(1'b1, 8'h02);
    check("R4", "no icw4 -> ready", {5'd0, phase}, {5'd0, P_READY});
    check("R4", "icw4 untouched", icw4_q, 8'h00);
  endtask

  task automatic t_restart_midway();
    do_reset();
    wr(1'b0, 8'h11); wr(1'b1, 8'h20);
    wr(1'b0, 8'h13);
    check("R2", "restart phase", {5'd0, phase}, {5'd0, P_SECOND});
    check("R2", "restart icw1", icw1_q, 8'h13);
    check("R13", "no err on restart", {7'd0, err}, 8'h00);
  endtask

  task automatic go_ready();
    do_reset();
    wr(1'b0, 8'h12); wr(1'b1, 8'h08);
  endtask

  task automatic t_specific_eoi();
    go_ready();
    mark(8'h29);
    check("R12", "isr set", isr, 8'h29);
    wr(1'b0, 8'h63); // level 3, SL, EOI
    check("R7", "specific clears bit3", isr, 8'h21);
    check("R7", "ocw2 stored", ocw2_q, 8'h63);
    wr(1'b0, 8'h60); // level 0
    check("R7", "specific clears bit0", isr, 8'h20);
  endtask

  task automatic t_lowest_eoi();
    logic [7:0] exp;
    go_ready();
    mark(8'hA4);
    exp = clear_lowest(8'hA4);
    wr(1'b0, 8'h20);
    check("R8", "lowest cleared", isr, exp);
    check("R8", "ocw2 stored", ocw2_q, 8'h20);
    exp = clear_lowest(exp);
    wr(1'b0, 8'h27); // level bits ignored
    check("R8", "next lowest", isr, exp);
    wr(1'b0, 8'h20);
    check("R8", "last bit", isr, 8'h00);
    wr(1'b0, 8'h20);
    check("R8", "empty stays empty", isr, 8'h00);
  endtask

  task automatic t_bad_end_cmd();
    go_ready();
    mark(8'h06);
    wr(1'b0, 8'h20);
    wr(1'b0, 8'hA0); // R=1
    check("R9", "err rotate form", {7'd0, err}, 8'h01);
    check("R9", "isr kept", isr, 8'h04);
    check("R9", "ocw2 kept", ocw2_q, 8'h20);
    check("R9", "phase kept", {5'd0, phase}, {5'd0, P_READY});
    wr(1'b0, 8'h43); // EOI=0
    check("R9", "err eoi=0", {7'd0, err}, 8'h01);
    check("R9", "isr kept 2", isr, 8'h04);
    @(negedge clk);
    check("R13", "err is one cycle", {7'd0, err}, 8'h00);
  endtask

  task automatic t_mode_byte();
    go_ready();
    wr(1'b0, 8'h0B);
    check("R10", "ocw3 stored", ocw3_q, 8'h0B);
    check("R13", "no err", {7'd0, err}, 8'h00);
  endtask

  task automatic t_reject_before_ready();
    do_reset();
    mark(8'h01);
    wr(1'b0, 8'h20);
    check("R11", "err in idle", {7'd0, err}, 8'h01);
    check("R11", "isr kept idle", isr, 8'h01);
    check("R11", "phase idle", {5'd0, phase}, {5'd0, P_IDLE});
    wr(1'b0, 8'h11);
    wr(1'b0, 8'h0B);
    check("R11", "err in second", {7'd0, err}, 8'h01);
    check("R11", "ocw3 kept", ocw3_q, 8'h00);
    check("R11", "phase second", {5'd0, phase}, {5'd0, P_SECOND});
  endtask

  task automatic t_set_clear_same_cycle();
    go_ready();
    mark(8'h08);
    drive(1'b1, 1'b0, 8'h63, 8'h09);
    check("R12", "clear beats set", isr, 8'h01);
    go_ready();
    mark(8'h04);
    drive(1'b1, 1'b0, 8'h20, 8'h01);
    check("R12", "lowest from old isr", isr, 8'h01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_mask_idle();
    t_init_cascade_need4();
    t_init_single_no4();
    t_init_single_need4();
    t_init_cascade_no4();
    t_restart_midway();
    t_specific_eoi();
    t_lowest_eoi();
    t_bad_end_cmd();
    t_mode_byte();
    t_reject_before_ready();
    t_set_clear_same_cycle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule